// File: doc/BRIEF.md
# Decimating Sampler for a Synchronous FIFO Write Port

This block captures an 8-bit probe bus and hands samples to the write side of an external synchronous byte FIFO. The FIFO device drives the clock. The block watches the FIFO's active-low space flag and drives an active-low write strobe together with the data byte. A byte moves into the FIFO on a rising edge only when the space flag and the strobe are both low in that cycle.

A programmable divisor N sets how often a sample falls due: one sample every N clock cycles, or every cycle when N is 1. A sample that falls due while the FIFO reports no space is discarded. Each discarded sample sets a sticky flag and bumps a saturating count. A pattern mode replaces the probe byte with a running count of accepted writes. The host can then detect any byte lost between the FIFO and itself as a step larger than one.

Top module: `decim_fifo_sampler`

## Requirements
- R1: After reset, the write strobe is high, the drop flag is 0, the drop count is 0 and the data byte is 0x00.
- R2: While enabled with the space flag held low and divisor N, the strobe goes low for one cycle every N cycles. The first strobe comes in cycle N, counting the first enabled cycle as cycle 0. Over C enabled cycles there are floor((C-1)/N) writes.
- R3: A divisor of 0 behaves exactly like a divisor of 1.
- R4: A new divisor value written during a period does not change that period. It takes effect from the next wrap of the divider.
- R5: In probe mode (pattern select low), each written byte is the probe bus value, passed through a two-flop synchronizer and captured on the wrap cycle. With the probe held steady, every written byte equals it.
- R6: A sample that falls due while the space flag is high produces no strobe. It sets the sticky drop flag and adds one to the drop count.
- R7: The 16-bit drop count saturates at 65535 and stays there while further drops occur.
- R8: A clear pulse returns the drop flag and the drop count to 0. Clear wins over a drop in the same cycle.
- R9: In pattern mode (pattern select high), each written byte equals the number of writes accepted since reset, modulo 256. This holds in either mode, and discarded samples never advance it.
- R10: While the enable is low the strobe stays high and the divider is held at the start of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the FIFO device |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Sampling enable; low blocks writes and holds the divider |
| test_mode | input | 1 | High selects the accepted-write count as data |
| clear | input | 1 | Synchronous clear of drop flag and drop count |
| div_value | input | 16 | Decimation divisor N (0 acts as 1) |
| probe_in | input | 8 | Asynchronous probe bus |
| fifo_space_n | input | 1 | Low while the FIFO can take a byte |
| fifo_wr_n | output | 1 | Active-low write strobe to the FIFO |
| fifo_data | output | 8 | Byte presented to the FIFO |
| drop_flag | output | 1 | Sticky flag: a due sample was discarded |
| drop_count | output | 16 | Saturating count of discarded samples |

## Verification
The strobe follows the space flag within the same cycle, and it can only fall in the cycle after a divider wrap. The first strobe therefore lands exactly N cycles after enable. A probe change reaches the data byte three edges later. Drop flag and count move one edge after the due cycle in which space was missing, and clear takes hold one edge after it is driven. The bench drives inputs just after the rising edge and samples everything at the falling edge. Each cycle is then settled before it is judged. Write positions are counted relative to the enabling edge, so first-strobe and interval checks compare exact cycle numbers.

// File: rtl/sampler_pkg.sv
package sampler_pkg;

  // Source of the byte presented to the FIFO.
  typedef enum logic {
    SRC_PROBE   = 1'b0,
    SRC_PATTERN = 1'b1
  } src_sel_e;

  localparam int unsigned SYNC_DEPTH = 2;

endpackage

// File: rtl/probe_sync.sv
module probe_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= '0;
        else        stage_q[gi] <= stage_q[gi-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_value,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] per_q, per_d;
  logic [DIV_W-1:0] eff_div;

  always_comb begin
    eff_div = (div_value == '0) ? ONE : div_value;
    tick    = enable && (cnt_q == (per_q - ONE));
  end

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    if (!enable) begin
      cnt_d = '0;
      per_d = eff_div;
    end else if (tick) begin
      cnt_d = '0;
      per_d = eff_div;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= ONE;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  p_period_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    per_q != '0);

endmodule

// File: rtl/drop_tracker.sv
module drop_tracker #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             drop,
  output logic             flag,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             flag_q, flag_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (clear) begin
      flag_d = 1'b0;
      cnt_d  = '0;
    end else if (drop) begin
      flag_d = 1'b1;
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag  = flag_q;
  assign count = cnt_q;

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clear) |=> flag_q);

  p_count_saturates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clear) |=> (cnt_q == CNT_MAX));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!flag_q && cnt_q == '0));

endmodule

// File: rtl/decim_fifo_sampler.sv
module decim_fifo_sampler #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              test_mode,
  input  logic              clear,
  input  logic [DIV_W-1:0]  div_value,
  input  logic [DATA_W-1:0] probe_in,
  input  logic              fifo_space_n,
  output logic              fifo_wr_n,
  output logic [DATA_W-1:0] fifo_data,
  output logic              drop_flag,
  output logic [CNT_W-1:0]  drop_count
);

  import sampler_pkg::*;

  logic              tick;
  logic [DATA_W-1:0] sync_data;
  logic              due_q, due_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [DATA_W-1:0] pat_q, pat_d;
  logic              accept, drop;
  src_sel_e          src;

  probe_sync #(.WIDTH(DATA_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (probe_in),
    .dout (sync_data)
  );

  rate_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .div_value(div_value),
    .tick     (tick)
  );

  drop_tracker #(.CNT_W(CNT_W)) u_drop (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .drop (drop),
    .flag (drop_flag),
    .count(drop_count)
  );

  // Handshake: a due sample goes out only if space exists this very cycle.
  always_comb begin
    accept = due_q && enable && !fifo_space_n;
    drop   = due_q && enable &&  fifo_space_n;
    src    = test_mode ? SRC_PATTERN : SRC_PROBE;
  end

  always_comb begin
    due_d  = tick;
    data_d = tick ? sync_data : data_q;
    pat_d  = accept ? pat_q + 1'b1 : pat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      due_q  <= 1'b0;
      data_q <= '0;
      pat_q  <= '0;
    end else begin
      due_q  <= due_d;
      data_q <= data_d;
      pat_q  <= pat_d;
    end
  end

  assign fifo_wr_n = !accept;
  assign fifo_data = (src == SRC_PATTERN) ? pat_q : data_q;

  p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(data_q));

  p_pattern_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_wr_n |=> (pat_q == $past(pat_q) + 1'b1));

  p_pattern_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_n |=> $stable(pat_q));

  p_strobe_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> fifo_wr_n);

  p_drop_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_space_n |-> fifo_wr_n);

endmodule

// File: tb/decim_fifo_sampler_tb.sv
`timescale 1ns/1ps
module decim_fifo_sampler_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, test_mode, clear, fifo_space_n;
  logic [15:0] div_value;
  logic [7:0]  probe_in;
  logic        fifo_wr_n;
  logic [7:0]  fifo_data;
  logic        drop_flag;
  logic [15:0] drop_count;

  always #4 clk = ~clk;

  decim_fifo_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .test_mode(test_mode),
    .clear(clear), .div_value(div_value), .probe_in(probe_in),
    .fifo_space_n(fifo_space_n), .fifo_wr_n(fifo_wr_n), .fifo_data(fifo_data),
    .drop_flag(drop_flag), .drop_count(drop_count)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor state, sampled at the falling edge.
  int cyc = 0;
  int en_cyc = 0;
  int win_writes = 0;
  int first_rel = 0;
  int acc_total = 0;
  bit probe_chk = 0;
  logic [7:0] probe_exp = '0;
  int wlog [16];
  int widx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && !fifo_wr_n) begin
      check(fifo_space_n == 1'b0, "R2 strobe needs space", fifo_space_n, 0);
      if (test_mode)
        check(fifo_data == acc_total[7:0], "R9 pattern byte", fifo_data, acc_total[7:0]);
      else if (probe_chk)
        check(fifo_data == probe_exp, "R5 probe byte", fifo_data, probe_exp);
      if (win_writes == 0) first_rel = cyc - en_cyc;
      if (widx < 16) wlog[widx] = cyc;
      widx++;
      win_writes++;
      acc_total++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse_clear();
    clear = 1'b1; step(1); clear = 1'b0;
  endtask

  task automatic run_enabled(input int c);
    win_writes = 0; first_rel = 0; widx = 0;
    enable = 1'b1; en_cyc = cyc;
    step(c);
    enable = 1'b0;
  endtask

  typedef struct packed {
    logic [15:0] div;
    logic        sp;
    logic        tm;
    logic [31:0] cycles;
    logic [31:0] writes;
    logic [31:0] drops;
    logic [31:0] first;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{div:16'd1,    sp:1'b0, tm:1'b1, cycles:32'd20,   writes:32'd19, drops:32'd0,  first:32'd1},
    '{div:16'd4,    sp:1'b0, tm:1'b1, cycles:32'd41,   writes:32'd10, drops:32'd0,  first:32'd4},
    '{div:16'd0,    sp:1'b0, tm:1'b0, cycles:32'd10,   writes:32'd9,  drops:32'd0,  first:32'd1},
    '{div:16'd7,    sp:1'b0, tm:1'b1, cycles:32'd50,   writes:32'd7,  drops:32'd0,  first:32'd7},
    '{div:16'd3,    sp:1'b1, tm:1'b0, cycles:32'd31,   writes:32'd0,  drops:32'd10, first:32'd0},
    '{div:16'd1000, sp:1'b0, tm:1'b1, cycles:32'd2001, writes:32'd2,  drops:32'd0,  first:32'd1000}
  };

  initial begin
    #(8 * 190000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; test_mode = 1'b0; clear = 1'b0;
    fifo_space_n = 1'b0; div_value = 16'd1; probe_in = 8'h00;
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fifo_wr_n == 1'b1, "R1 strobe idle", fifo_wr_n, 1);
    check(drop_flag == 1'b0, "R1 flag", drop_flag, 0);
    check(drop_count == 16'd0, "R1 count", drop_count, 0);
    check(fifo_data == 8'h00, "R1 data", fifo_data, 0);
    step(1);

    // R10: disabled, space available: nothing written
    win_writes = 0; en_cyc = cyc;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(fifo_wr_n == 1'b1, "R10 strobe high while disabled", fifo_wr_n, 1);
    end
    step(1);
    check(win_writes == 0, "R10 no writes", win_writes, 0);

    // Table walk: R2, R3, R6, R9
    foreach (VECS[k]) begin
      div_value = VECS[k].div; fifo_space_n = VECS[k].sp; test_mode = VECS[k].tm;
      step(2);
      pulse_clear();
      run_enabled(int'(VECS[k].cycles));
      step(2);
      check(win_writes == int'(VECS[k].writes), "R2/R3 write count", win_writes, VECS[k].writes);
      if (VECS[k].writes != 0)
        check(first_rel == int'(VECS[k].first), "R2/R3 first strobe cycle", first_rel, VECS[k].first);
      check(drop_count == VECS[k].drops[15:0], "R6 drop count", drop_count, VECS[k].drops);
      check(drop_flag == (VECS[k].drops != 0), "R6 drop flag", drop_flag, VECS[k].drops != 0);
    end
    fifo_space_n = 1'b0;

    // R5: probe capture, two held values
    test_mode = 1'b0; div_value = 16'd2;
    probe_in = 8'h5A; probe_exp = 8'h5A; step(4);
    probe_chk = 1;
    run_enabled(21);
    check(win_writes == 10, "R5 writes with probe A", win_writes, 10);
    probe_chk = 0; probe_in = 8'hC3; probe_exp = 8'hC3; step(4);
    probe_chk = 1;
    run_enabled(21);
    check(win_writes == 10, "R5 writes with probe B", win_writes, 10);
    probe_chk = 0; step(2);

    // R4: divisor change mid-period takes effect from the next wrap
    div_value = 16'd5; step(2);
    win_writes = 0; widx = 0; enable = 1'b1; en_cyc = cyc;
    while (win_writes < 2) step(1);
    div_value = 16'd2;
    while (win_writes < 5) step(1);
    enable = 1'b0;
    check(wlog[1] - wlog[0] == 5, "R4 interval before change", wlog[1] - wlog[0], 5);
    check(wlog[2] - wlog[1] == 5, "R4 interval of current period", wlog[2] - wlog[1], 5);
    check(wlog[3] - wlog[2] == 2, "R4 new interval after wrap", wlog[3] - wlog[2], 2);
    check(wlog[4] - wlog[3] == 2, "R4 new interval holds", wlog[4] - wlog[3], 2);
    step(2);

    // R9: space toggling each cycle in pattern mode; drops never skip a value
    test_mode = 1'b1; div_value = 16'd1; step(2);
    pulse_clear();
    win_writes = 0; enable = 1'b1; en_cyc = cyc;
    for (int i = 0; i < 40; i++) begin
      fifo_space_n = i[0];
      step(1);
    end
    enable = 1'b0; fifo_space_n = 1'b0;
    step(2);
    check(win_writes + int'(drop_count) == 39, "R9 writes plus drops", win_writes + int'(drop_count), 39);
    check(drop_count != 16'd0, "R9 some drops seen", drop_count, 1);

    // R8: clear wins over a simultaneous drop
    fifo_space_n = 1'b1; enable = 1'b1;
    step(10);
    clear = 1'b1; step(1); clear = 1'b0;
    @(negedge clk);
    check(drop_count == 16'd0, "R8 count cleared", drop_count, 0);
    check(drop_flag == 1'b0, "R8 flag cleared", drop_flag, 0);
    enable = 1'b0; step(2);
    pulse_clear(); step(1);
    check(drop_count == 16'd0, "R8 count after idle clear", drop_count, 0);

    // R7: saturation of the drop count
    fifo_space_n = 1'b1; enable = 1'b1;
    step(65600);
    enable = 1'b0; step(2);
    check(drop_count == 16'hFFFF, "R7 count saturated", drop_count, 65535);
    check(drop_flag == 1'b1, "R7 flag set", drop_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule